// File: doc/BRIEF.md
# Prioritised Speech Event Queue

This block gathers requests for spoken messages and turns each into an 8-bit vector for a downstream playback engine. Requests come from six hardware pins and from one software trigger. The hardware pins are a CPU-presence level and five trap inputs. The software trigger is armed behind a watchdog that counts seconds. Requests that land in the same clock cycle are ordered by a fixed priority. The winners are written one per cycle into an eight-entry vector FIFO, which the consumer drains through a pop/empty interface.

Firmware programs the watchdog through a simple write port that carries an index and a data byte. The watchdog works as a progress monitor. Firmware loads a limit and a 7-bit message code, then keeps rewriting the limit while it makes progress. If the 1 Hz tick count ever reaches the limit, the stored message is queued one time and the timer stops until the limit is written again.

The watchdog is a three-state machine:
- WD_IDLE is the state after reset. The timer is not armed.
- WD_RUN is counting. On an enabled tick the counter steps up by one.
- WD_DONE is entered when the counter equals the limit while counting is enabled. That transition queues the software event.

A write to the limit register takes the machine from any state to WD_RUN with the counter at zero. This is the arm/restart transition.

Top module: `speech_evt_queue`

## Requirements
- R1: After reset the queue is empty (`empty_o`=1) and `overflow_o`=0.
- R2: A low-to-high transition on trap input k (k=1..5, bit k-1 of `trap_i`) queues vector k+1. Holding the input high or taking it low queues nothing more.
- R3: Any transition of `cpu_absent_i` queues vector 0x01. Low means a CPU is present and high means it is absent. The input is taken as low at reset.
- R4: Events detected in the same cycle are queued in this order: CPU input, trap 1, 2, 3, 4, 5, then the software event. Exactly one event is queued per cycle.
- R5: The write port uses three registers. Index 0x08 is the 8-bit limit. Index 0x09 holds the message code in bits 6:0. Index 0x0A holds the count enable in bit 6. When the counter equals the limit while enabled, vector {1'b1, code} (0x80|code) is queued. Limit 0 fires right after arming.
- R6: Writing index 0x08 clears the counter and restarts the timer. Rewrites that arrive before expiry prevent any software event.
- R7: After firing, the software event is not queued again until index 0x08 is rewritten.
- R8: Ticks received while the enable bit is 0 do not advance the counter.
- R9: The queue holds 8 vectors in first-in first-out order. `vec_o` shows the oldest entry whenever `empty_o`=0, and `pop_i` removes it.
- R10: An event detected while the queue is full is dropped and sets `overflow_o`, which stays set until reset. Events pending from before stay pending until granted.
- R11: `pop_i` while empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_absent_i | input | 1 | CPU presence level (1 = absent) |
| trap_i | input | 5 | External trap inputs, rising-edge active |
| tick_i | input | 1 | One-cycle pulse once per second |
| reg_we_i | input | 1 | Register write strobe |
| reg_idx_i | input | 8 | Register index |
| reg_wdata_i | input | 8 | Register write data |
| pop_i | input | 1 | Consumer removes head vector |
| empty_o | output | 1 | Queue empty |
| vec_o | output | 8 | Head vector |
| overflow_o | output | 1 | Sticky drop flag |

## Verification
The bench raises every hardware input together with a software expiry in the same cycle. A wrong priority encoder would pop the vectors out of order. It also checks that a held trap level is not re-queued, which catches level detection in place of edge detection. It then rewrites the limit repeatedly just before expiry and keeps ticking after a firing. A timer that does not restart, or one that re-fires, would emit extra 0x80-range vectors. Finally it ticks with counting disabled and pushes nine events into the eight-entry queue. A design that counts while disabled would fire early. One that overwrites a full queue, or clears the overflow flag, would show wrong vectors or a wrong flag.

// File: rtl/evq_pkg.sv
package evq_pkg;
    localparam logic [7:0] IDX_LIMIT   = 8'h08;
    localparam logic [7:0] IDX_CODE    = 8'h09;
    localparam logic [7:0] IDX_CTRL    = 8'h0A;
    localparam int         CTRL_EN_BIT = 6;
    localparam logic [7:0] VEC_CPU     = 8'h01;

    typedef enum logic [1:0] {
        WD_IDLE = 2'd0,
        WD_RUN  = 2'd1,
        WD_DONE = 2'd2
    } wd_state_t;
endpackage

// File: rtl/evq_watchdog.sv
module evq_watchdog
    import evq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             arm_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             fire_o
);
    wd_state_t        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             match;

    assign match = (cnt_q == limit_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WD_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_IDLE: if (arm_i) state_d = WD_RUN;
            WD_RUN: begin
                if (arm_i)              state_d = WD_RUN;
                else if (en_i && match) state_d = WD_DONE;
            end
            WD_DONE: if (arm_i) state_d = WD_RUN;
            default: state_d = WD_IDLE;
        endcase
    end

    always_comb begin
        fire_o = 1'b0;
        unique case (state_q)
            WD_RUN:  fire_o = en_i && match && !arm_i;
            WD_IDLE,
            WD_DONE: fire_o = 1'b0;
            default: fire_o = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (arm_i)
            cnt_q <= '0;
        else if (state_q == WD_RUN && en_i && tick_i && !match)
            cnt_q <= cnt_q + 1'b1;
    end

    AST_FIRE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> (state_q == WD_DONE)); // R7
    AST_ARM_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        arm_i |=> (cnt_q == '0 && state_q == WD_RUN)); // R6
    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !arm_i) |=> $stable(cnt_q)); // R8
endmodule

// File: rtl/evq_arbiter.sv
module evq_arbiter #(
    parameter int N_SRC = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] req_i,
    input  logic             full_i,
    output logic [N_SRC-1:0] grant_o,
    output logic             push_o,
    output logic             drop_o
);
    logic [N_SRC-1:0] pending_q;

    // index 0 has the highest priority
    always_comb begin
        grant_o = '0;
        if (!full_i) begin
            for (int i = N_SRC - 1; i >= 0; i--) begin
                if (pending_q[i]) grant_o = N_SRC'(1) << i;
            end
        end
    end

    assign push_o = |grant_o;
    assign drop_o = full_i && (|req_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pending_q <= '0;
        else        pending_q <= (pending_q & ~grant_o) | (req_i & {N_SRC{!full_i}});
    end

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o)); // R4
    AST_TOP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_q[0] && !full_i) |-> grant_o[0]); // R4
    AST_KEEP_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        full_i |=> ((pending_q & $past(pending_q)) == $past(pending_q))); // R10
endmodule

// File: rtl/evq_fifo.sv
module evq_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] din_i,
    input  logic         pop_i,
    output logic [W-1:0] dout_o,
    output logic         empty_o,
    output logic         full_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem_q [DEPTH];
    logic [AW-1:0] wr_q, rd_q;
    logic [CW-1:0] count_q;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty_o = (count_q == '0);
    assign full_o  = (count_q == CW'(DEPTH));
    assign do_push = push_i && !full_o;
    assign do_pop  = pop_i && !empty_o;
    assign dout_o  = mem_q[rd_q];

    always_ff @(posedge clk) begin
        if (do_push) mem_q[wr_q] <= din_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q    <= '0;
            rd_q    <= '0;
            count_q <= '0;
        end else begin
            if (do_push) wr_q <= nxt(wr_q);
            if (do_pop)  rd_q <= nxt(rd_q);
            count_q <= count_q + CW'(do_push) - CW'(do_pop);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !(push_i && full_o)); // R10
    AST_IDLE_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && empty_o && !push_i) |=> empty_o); // R11
    AST_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CW'(DEPTH)); // R9
endmodule

// File: rtl/speech_evt_queue.sv
module speech_evt_queue
    import evq_pkg::*;
#(
    parameter int N_TRAP = 5,
    parameter int DEPTH  = 8,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_absent_i,
    input  logic [N_TRAP-1:0] trap_i,
    input  logic              tick_i,
    input  logic              reg_we_i,
    input  logic [7:0]        reg_idx_i,
    input  logic [7:0]        reg_wdata_i,
    input  logic              pop_i,
    output logic              empty_o,
    output logic [7:0]        vec_o,
    output logic              overflow_o
);
    localparam int N_SRC  = N_TRAP + 2;
    localparam int SW_IDX = N_SRC - 1;

    logic [CNT_W-1:0]  limit_q;
    logic [6:0]        code_q;
    logic              en_q;
    logic              cpu_q;
    logic [N_TRAP-1:0] trap_q;
    logic              arm, fire, push, drop, full;
    logic [N_SRC-1:0]  req, grant;
    logic [7:0]        push_vec;

    assign arm = reg_we_i && (reg_idx_i == IDX_LIMIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            limit_q <= '0;
            code_q  <= '0;
            en_q    <= 1'b0;
        end else if (reg_we_i) begin
            unique case (reg_idx_i)
                IDX_LIMIT: limit_q <= reg_wdata_i[CNT_W-1:0];
                IDX_CODE:  code_q  <= reg_wdata_i[6:0];
                IDX_CTRL:  en_q    <= reg_wdata_i[CTRL_EN_BIT];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpu_q      <= 1'b0;
            trap_q     <= '0;
            overflow_o <= 1'b0;
        end else begin
            cpu_q  <= cpu_absent_i;
            trap_q <= trap_i;
            if (drop) overflow_o <= 1'b1;
        end
    end

    assign req[0] = cpu_absent_i ^ cpu_q;
    for (genvar g = 0; g < N_TRAP; g++) begin : g_trap_edge
        assign req[g+1] = trap_i[g] & ~trap_q[g];
    end
    assign req[SW_IDX] = fire;

    always_comb begin
        push_vec = 8'h00;
        for (int i = 0; i < N_SRC; i++) begin
            if (grant[i]) begin
                if (i == SW_IDX) push_vec = {1'b1, code_q};
                else             push_vec = VEC_CPU + 8'(i);
            end
        end
    end

    evq_watchdog #(.CNT_W(CNT_W)) u_wd (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (en_q),
        .arm_i   (arm),
        .tick_i  (tick_i),
        .limit_i (limit_q),
        .fire_o  (fire)
    );

    evq_arbiter #(.N_SRC(N_SRC)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req),
        .full_i  (full),
        .grant_o (grant),
        .push_o  (push),
        .drop_o  (drop)
    );

    evq_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push),
        .din_i   (push_vec),
        .pop_i   (pop_i),
        .dout_o  (vec_o),
        .empty_o (empty_o),
        .full_o  (full)
    );

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |=> overflow_o); // R10
    AST_VEC_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (push_vec != 8'h00)); // R2
endmodule

// File: tb/speech_evt_queue_test.sv
module speech_evt_queue_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_absent_i = 1'b0;
    logic [4:0] trap_i = '0;
    logic       tick_i = 1'b0;
    logic       reg_we_i = 1'b0;
    logic [7:0] reg_idx_i = '0;
    logic [7:0] reg_wdata_i = '0;
    logic       pop_i = 1'b0;
    logic       empty_o;
    logic [7:0] vec_o;
    logic       overflow_o;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    speech_evt_queue uut (
        .clk(clk), .rst_n(rst_n), .cpu_absent_i(cpu_absent_i), .trap_i(trap_i),
        .tick_i(tick_i), .reg_we_i(reg_we_i), .reg_idx_i(reg_idx_i),
        .reg_wdata_i(reg_wdata_i), .pop_i(pop_i), .empty_o(empty_o),
        .vec_o(vec_o), .overflow_o(overflow_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] idx, input logic [7:0] dat);
        @(negedge clk);
        reg_we_i = 1'b1; reg_idx_i = idx; reg_wdata_i = dat;
        @(negedge clk);
        reg_we_i = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk); tick_i = 1'b1;
        @(negedge clk); tick_i = 1'b0;
    endtask

    task automatic pop_exp(input string req, input logic [7:0] exp);
        chk(req, empty_o, 1'b0);
        chk(req, vec_o, exp);
        pop_i = 1'b1;
        @(negedge clk);
        pop_i = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 empty", empty_o, 1'b1);
        chk("R1 overflow", overflow_o, 1'b0);
    endtask

    task automatic t_trap_edges();
        @(negedge clk); trap_i[2] = 1'b1;
        wait_cyc(8);
        pop_exp("R2 trap3 vector", 8'h04);
        chk("R2 held level no repeat", empty_o, 1'b1);
        trap_i[2] = 1'b0;
        wait_cyc(4);
        chk("R2 falling edge ignored", empty_o, 1'b1);
    endtask

    task automatic t_cpu();
        @(negedge clk); cpu_absent_i = 1'b1;
        wait_cyc(4);
        pop_exp("R3 cpu absent", 8'h01);
        cpu_absent_i = 1'b0;
        wait_cyc(4);
        pop_exp("R3 cpu present", 8'h01);
        chk("R3 single event", empty_o, 1'b1);
    endtask

    task automatic t_priority();
        wr(8'h0A, 8'h40);
        wr(8'h09, 8'hAA);   // bit 7 of the code byte is ignored
        @(negedge clk);
        reg_we_i = 1'b1; reg_idx_i = 8'h08; reg_wdata_i = 8'h00;
        @(negedge clk);
        reg_we_i = 1'b0;
        cpu_absent_i = 1'b1;
        trap_i = 5'h1F;
        wait_cyc(10);
        pop_exp("R4 order cpu", 8'h01);
        for (int k = 1; k <= 5; k++) pop_exp("R4 order trap", 8'(k + 1));
        pop_exp("R4 R5 order software", 8'hAA);
        chk("R4 drained", empty_o, 1'b1);
        trap_i = '0;
        cpu_absent_i = 1'b0;
        wait_cyc(4);
        pop_exp("R3 cpu return", 8'h01);
    endtask

    task automatic t_sw_rewrite();
        wr(8'h09, 8'h15);
        wr(8'h08, 8'h03);
        tick(); tick();
        wr(8'h08, 8'h03);
        tick(); tick();
        wr(8'h08, 8'h03);
        tick(); tick();
        wait_cyc(4);
        chk("R6 rewrite keeps quiet", empty_o, 1'b1);
        tick();
        wait_cyc(4);
        pop_exp("R5 expiry vector", 8'h95);
        for (int k = 0; k < 5; k++) tick();
        wait_cyc(4);
        chk("R7 fires once", empty_o, 1'b1);
        wr(8'h08, 8'h01);
        wait_cyc(3);
        chk("R7 rearm waits for tick", empty_o, 1'b1);
        tick();
        wait_cyc(4);
        pop_exp("R7 rearm fires", 8'h95);
    endtask

    task automatic t_enable_gate();
        wr(8'h0A, 8'h00);
        wr(8'h08, 8'h02);
        for (int k = 0; k < 5; k++) tick();
        wait_cyc(4);
        chk("R8 disabled no fire", empty_o, 1'b1);
        wr(8'h0A, 8'h40);
        wait_cyc(3);
        chk("R8 counter held at zero", empty_o, 1'b1);
        tick();
        wait_cyc(4);
        chk("R8 one tick short", empty_o, 1'b1);
        tick();
        wait_cyc(4);
        pop_exp("R8 fires after enabled ticks", 8'h95);
    endtask

    task automatic t_pop_empty();
        @(negedge clk); pop_i = 1'b1;
        wait_cyc(3);
        pop_i = 1'b0;
        chk("R11 still empty", empty_o, 1'b1);
        trap_i[4] = 1'b1;
        wait_cyc(4);
        trap_i[4] = 1'b0;
        pop_exp("R11 queue intact", 8'h06);
        chk("R11 empty again", empty_o, 1'b1);
    endtask

    task automatic t_fifo_order();
        @(negedge clk); trap_i[1] = 1'b1;
        @(negedge clk); trap_i[3] = 1'b1;
        @(negedge clk); trap_i[0] = 1'b1;
        wait_cyc(4);
        trap_i = '0;
        pop_exp("R9 first in", 8'h03);
        pop_exp("R9 second", 8'h05);
        pop_exp("R9 third", 8'h02);
        chk("R9 empty", empty_o, 1'b1);
    endtask

    task automatic t_overflow();
        for (int k = 0; k < 9; k++) begin
            @(negedge clk); trap_i[0] = 1'b1;
            @(negedge clk); trap_i[0] = 1'b0;
            wait_cyc(3);
            if (k == 7) chk("R10 no flag at exactly full", overflow_o, 1'b0);
        end
        chk("R10 overflow set", overflow_o, 1'b1);
        for (int k = 0; k < 8; k++) pop_exp("R10 kept entries", 8'h02);
        wait_cyc(3);
        chk("R10 ninth dropped", empty_o, 1'b1);
        chk("R10 sticky", overflow_o, 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        t_reset();
        t_trap_edges();
        t_cpu();
        t_priority();
        t_sw_rewrite();
        t_enable_gate();
        t_pop_empty();
        t_fifo_order();
        t_overflow();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule